// File: doc/BRIEF.md
# Virtual Data Address Region and Permission Checker

This block decides, for one data access, whether a virtual address goes straight through to a physical address, is rejected by the address region rules, or needs the translation look-aside buffer's answer. A set of fixed regions above the 2 GiB line bypasses translation, and which of them are reachable depends on the privilege mode. The rest of the space either maps directly onto the low 29 bits of the address (translation off) or is resolved through the hit, miss or multi-hit status and the protection bits of a unified TLB that sits outside this block.

The decision path is purely combinational. It produces either a physical address or exactly one exception code, never both. A small register stage holds the virtual address of the latest TLB-related fault, together with its page-number field. A qualified access strobe gates that update, so idle cycles leave the stored values alone.

Top module: `va_perm_checker`

## Requirements
- R1: In privileged mode (priv=1), an address at or above 0xE0000000 gives pa equal to va. An address from 0x80000000 to 0xBFFFFFFF gives pa = va with bits 31:29 cleared. Both report exc=0 (none), whatever the TLB inputs are.
- R2: In user mode (priv=0), an address with bit 31 set gives pa=va with exc=0 only if it lies in 0xE0000000..0xE3FFFFFF and sq_user_dis=0. Any other such address raises exc=1 (address error, read) or exc=2 (address error, write).
- R3: With xlate_en=0, every address not handled by R1 or R2 gives pa = va with bits 31:29 cleared and exc=0. This includes privileged addresses from 0xC0000000 to 0xDFFFFFFF.
- R4: With translation on, lk_status=0 (miss) raises exc=3 on a read and exc=4 on a write. lk_status=2 or 3 (multi-hit) raises exc=5.
- R5: On a hit (lk_status=1), a user-mode read of an entry with ent_user=0 raises exc=6 (read protection). A privileged read needs no permission bit.
- R6: On a hit, a privileged write needs ent_writable=1, and a user write needs both ent_user=1 and ent_writable=1. A write that lacks them raises exc=7 (write protection).
- R7: On a hit, a write that passes R6 but has ent_dirty=0 raises exc=8 (initial page write). Reads ignore ent_dirty.
- R8: On a hit that passes all checks, pa = (ent_ppn AND ent_mask) OR (va AND NOT ent_mask) and exc=0.
- R9: Exactly one code is reported, with this priority: address error, then miss or multi-hit, then protection, then dirty. Whenever exc is not 0, pa is 0.
- R10: fault_va_q and fault_vpn_q reset to 0. They load va and va[31:10] at the clock edge ending a cycle with acc_valid=1 and exc in 3..8. In any other cycle, including one with an address error, they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Qualifies the access for fault capture |
| va | input | 32 | Virtual data address |
| is_write | input | 1 | 1 = write access, 0 = read |
| priv | input | 1 | 1 = privileged mode |
| xlate_en | input | 1 | Address translation enable |
| sq_user_dis | input | 1 | Blocks user access to the store-queue window |
| lk_status | input | 2 | TLB lookup: 0 miss, 1 hit, 2 or 3 multi-hit |
| ent_ppn | input | 32 | Physical page number of the hit entry |
| ent_mask | input | 32 | Page-size mask of the hit entry |
| ent_user | input | 1 | Entry user-access bit |
| ent_writable | input | 1 | Entry writable bit |
| ent_dirty | input | 1 | Entry dirty bit |
| pa | output | 32 | Physical address, 0 on a fault |
| exc | output | 4 | Exception code, 0 = none |
| fault_va_q | output | 32 | Captured faulting virtual address |
| fault_vpn_q | output | 22 | Captured page-number field va[31:10] |

## Verification
The bench targets the region edges: 0xBFFFFFFF against 0xC0000000 in privileged mode, and 0xE3FFFFFF against 0xE4000000 with the store-queue disable bit both set and clear in user mode. A design that got these wrong would either translate a bypass address or grant a user a forbidden window. It also drives combinations that raise several faults at once. Examples are a miss on a user region error, and a clean but write-protected page. A wrong priority order would show there as the wrong code, or as a nonzero pa next to a fault. Fault capture is exercised with address errors and with strobe-low faults, which must leave the stored address untouched. A capture condition that was too broad would overwrite the fault address with these.

// File: rtl/vachk_pkg.sv
package vachk_pkg;
    localparam int unsigned VA_W = 32;

    typedef enum logic [3:0] {
        EXC_NONE    = 4'd0,
        EXC_ADDR_RD = 4'd1,
        EXC_ADDR_WR = 4'd2,
        EXC_MISS_RD = 4'd3,
        EXC_MISS_WR = 4'd4,
        EXC_MULTI   = 4'd5,
        EXC_PROT_RD = 4'd6,
        EXC_PROT_WR = 4'd7,
        EXC_INIT_WR = 4'd8
    } exc_e;

    typedef enum logic [1:0] {
        LK_MISS   = 2'd0,
        LK_HIT    = 2'd1,
        LK_MULTI  = 2'd2,
        LK_MULTI2 = 2'd3
    } lk_e;

    // Outcome of the fixed region decode
    typedef struct packed {
        logic            bypass;
        logic            addr_err;
        logic [VA_W-1:0] pa;
    } region_t;

    function automatic logic is_tlb_fault(exc_e e);
        return (e >= EXC_MISS_RD) && (e <= EXC_INIT_WR);
    endfunction
endpackage

// File: rtl/va_region_decode.sv
module va_region_decode
    import vachk_pkg::*;
#(
    parameter int unsigned EXT_BITS = 29
) (
    input  logic [VA_W-1:0] va,
    input  logic            priv,
    input  logic            xlate_en,
    input  logic            sq_user_dis,
    output region_t         rgn
);
    localparam logic [VA_W-1:0] EXT_MASK = VA_W'((64'd1 << EXT_BITS) - 64'd1);

    logic [VA_W-1:0] ext_addr;
    assign ext_addr = va & EXT_MASK;

    always_comb begin
        rgn = '0;
        if (va[VA_W-1]) begin
            if (priv) begin
                if (va[VA_W-1 -: 3] == 3'b111) begin
                    rgn.bypass = 1'b1;
                    rgn.pa     = va;
                end else if (va[VA_W-1 -: 2] == 2'b10) begin
                    rgn.bypass = 1'b1;
                    rgn.pa     = ext_addr;
                end
            end else if (va[VA_W-1 -: 6] == 6'b111000 && !sq_user_dis) begin
                rgn.bypass = 1'b1;
                rgn.pa     = va;
            end else begin
                rgn.addr_err = 1'b1;
            end
        end
        if (!rgn.bypass && !rgn.addr_err && !xlate_en) begin
            rgn.bypass = 1'b1;
            rgn.pa     = ext_addr;
        end
    end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import vachk_pkg::*;
(
    input  logic [1:0] lk_status,
    input  logic       is_write,
    input  logic       priv,
    input  logic       ent_user,
    input  logic       ent_writable,
    input  logic       ent_dirty,
    output exc_e       tlb_exc
);
    logic wr_ok;
    assign wr_ok = priv ? ent_writable : (ent_writable && ent_user);

    always_comb begin
        tlb_exc = EXC_NONE;
        unique case (lk_e'(lk_status))
            LK_MISS: tlb_exc = is_write ? EXC_MISS_WR : EXC_MISS_RD;
            LK_HIT: begin
                if (is_write) begin
                    if (!wr_ok)          tlb_exc = EXC_PROT_WR;
                    else if (!ent_dirty) tlb_exc = EXC_INIT_WR;
                end else if (!priv && !ent_user) begin
                    tlb_exc = EXC_PROT_RD;
                end
            end
            default: tlb_exc = EXC_MULTI;
        endcase
    end
endmodule

// File: rtl/fault_capture.sv
module fault_capture
    import vachk_pkg::*;
#(
    parameter int unsigned PAGE_LSB = 10,
    localparam int unsigned VPN_W = VA_W - PAGE_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [VA_W-1:0]  va,
    output logic [VA_W-1:0]  fault_va_q,
    output logic [VPN_W-1:0] fault_vpn_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fault_va_q  <= '0;
            fault_vpn_q <= '0;
        end else if (capture) begin
            fault_va_q  <= va;
            fault_vpn_q <= va[VA_W-1:PAGE_LSB];
        end
    end

    // R10
    fault_load_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> (fault_vpn_q == fault_va_q[VA_W-1:PAGE_LSB]) && (fault_va_q == $past(va)));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(fault_va_q) && $stable(fault_vpn_q));
endmodule

// File: rtl/va_perm_checker.sv
module va_perm_checker
    import vachk_pkg::*;
#(
    parameter int unsigned EXT_BITS = 29,
    parameter int unsigned PAGE_LSB = 10,
    localparam int unsigned VPN_W = VA_W - PAGE_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [VA_W-1:0]  va,
    input  logic             is_write,
    input  logic             priv,
    input  logic             xlate_en,
    input  logic             sq_user_dis,
    input  logic [1:0]       lk_status,
    input  logic [VA_W-1:0]  ent_ppn,
    input  logic [VA_W-1:0]  ent_mask,
    input  logic             ent_user,
    input  logic             ent_writable,
    input  logic             ent_dirty,
    output logic [VA_W-1:0]  pa,
    output logic [3:0]       exc,
    output logic [VA_W-1:0]  fault_va_q,
    output logic [VPN_W-1:0] fault_vpn_q
);
    region_t         rgn;
    exc_e            tlb_exc;
    exc_e            exc_sel;
    logic [VA_W-1:0] pa_xlat;

    va_region_decode #(.EXT_BITS(EXT_BITS)) u_region (
        .va          (va),
        .priv        (priv),
        .xlate_en    (xlate_en),
        .sq_user_dis (sq_user_dis),
        .rgn         (rgn)
    );

    tlb_perm_check u_perm (
        .lk_status    (lk_status),
        .is_write     (is_write),
        .priv         (priv),
        .ent_user     (ent_user),
        .ent_writable (ent_writable),
        .ent_dirty    (ent_dirty),
        .tlb_exc      (tlb_exc)
    );

    assign pa_xlat = (ent_ppn & ent_mask) | (va & ~ent_mask);

    // Address error outranks everything; bypass masks the TLB result
    always_comb begin
        if (rgn.addr_err)    exc_sel = is_write ? EXC_ADDR_WR : EXC_ADDR_RD;
        else if (rgn.bypass) exc_sel = EXC_NONE;
        else                 exc_sel = tlb_exc;
    end

    assign exc = exc_sel;
    assign pa  = (exc_sel != EXC_NONE) ? '0 : (rgn.bypass ? rgn.pa : pa_xlat);

    fault_capture #(.PAGE_LSB(PAGE_LSB)) u_fault (
        .clk         (clk),
        .rst         (rst),
        .capture     (acc_valid && is_tlb_fault(exc_sel)),
        .va          (va),
        .fault_va_q  (fault_va_q),
        .fault_vpn_q (fault_vpn_q)
    );

    // R1
    priv_high_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (priv && va[VA_W-1 -: 3] == 3'b111) |-> (pa == va && exc == 4'd0));

    // R2
    user_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!priv && va[VA_W-1]) |-> ((exc == 4'd0 && pa == va) || exc == 4'd1 || exc == 4'd2));

    // R7
    init_wr_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        (exc == 4'd8) |-> (is_write && lk_status == 2'd1 && !ent_dirty));

    // R8
    page_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (xlate_en && !va[VA_W-1] && exc == 4'd0) |-> ((pa & ~ent_mask) == (va & ~ent_mask)));

    // R9
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (exc != 4'd0) |-> (pa == '0));
endmodule

// File: tb/test_va_perm_checker.sv
module test_va_perm_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] va = '0;
    logic        is_write = 1'b0;
    logic        priv = 1'b0;
    logic        xlate_en = 1'b0;
    logic        sq_user_dis = 1'b0;
    logic [1:0]  lk_status = '0;
    logic [31:0] ent_ppn = '0;
    logic [31:0] ent_mask = '0;
    logic        ent_user = 1'b0;
    logic        ent_writable = 1'b0;
    logic        ent_dirty = 1'b0;
    logic [31:0] pa;
    logic [3:0]  exc;
    logic [31:0] fault_va_q;
    logic [21:0] fault_vpn_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] exp_fva = '0;

    always #10 clk = ~clk;

    va_perm_checker i_va_perm_checker (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .va(va), .is_write(is_write),
        .priv(priv), .xlate_en(xlate_en), .sq_user_dis(sq_user_dis),
        .lk_status(lk_status), .ent_ppn(ent_ppn), .ent_mask(ent_mask),
        .ent_user(ent_user), .ent_writable(ent_writable), .ent_dirty(ent_dirty),
        .pa(pa), .exc(exc), .fault_va_q(fault_va_q), .fault_vpn_q(fault_vpn_q)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Behavioural reference built from the requirement list
    function automatic void model(input logic [31:0] a, input bit w, p, x, sq,
                                  input logic [1:0] lk, input logic [31:0] ppn, msk,
                                  input bit u, wr, d,
                                  output int e, output logic [31:0] epa, output string tag);
        bit ok;
        e = 0; epa = '0;
        if (a[31] && !p) begin
            tag = "R2";
            if (a >= 32'hE000_0000 && a < 32'hE400_0000 && !sq) epa = a;
            else e = w ? 2 : 1;
            return;
        end
        if (a[31] && p && a >= 32'hE000_0000) begin tag = "R1"; epa = a; return; end
        if (a[31] && p && a < 32'hC000_0000) begin tag = "R1"; epa = a & 32'h1FFF_FFFF; return; end
        if (!x) begin tag = "R3"; epa = a & 32'h1FFF_FFFF; return; end
        if (lk == 2'd0) begin tag = "R4"; e = w ? 4 : 3; end
        else if (lk >= 2'd2) begin tag = "R4"; e = 5; end
        else if (w) begin
            ok = p ? wr : (wr && u);
            if (!ok) begin tag = "R6"; e = 7; end
            else if (!d) begin tag = "R7"; e = 8; end
            else tag = "R8";
        end else if (!p && !u) begin tag = "R5"; e = 6; end
        else tag = "R8";
        if (e == 0) epa = (ppn & msk) | (a & ~msk);
    endfunction

    task automatic acc(string dtag, logic [31:0] a, bit w, p, x, sq, logic [1:0] lk,
                       logic [31:0] ppn, msk, bit u, wr, d, bit v = 1);
        int e; logic [31:0] epa; string mtag;
        va = a; is_write = w; priv = p; xlate_en = x; sq_user_dis = sq;
        lk_status = lk; ent_ppn = ppn; ent_mask = msk;
        ent_user = u; ent_writable = wr; ent_dirty = d; acc_valid = v;
        #2;
        model(a, w, p, x, sq, lk, ppn, msk, u, wr, d, e, epa, mtag);
        check({dtag, "/", mtag, " exc"}, 64'(exc), 64'(e));
        check({dtag, "/", mtag, " pa"}, 64'(pa), 64'(epa));
        if (v && e >= 3 && e <= 8) exp_fva = a;
        @(posedge clk);
        #1;
        check({dtag, " R10 fault_va"}, 64'(fault_va_q), 64'(exp_fva));
        check({dtag, " R10 fault_vpn"}, 64'(fault_vpn_q), 64'(exp_fva[31:10]));
        @(negedge clk);
    endtask

    localparam logic [31:0] M1K = 32'hFFFF_FC00;
    localparam logic [31:0] M4K = 32'hFFFF_F000;
    localparam logic [31:0] M1M = 32'hFFF0_0000;

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 reset fault_va", 64'(fault_va_q), 64'd0);
        check("R10 reset fault_vpn", 64'(fault_vpn_q), 64'd0);

        // R1 privileged fixed regions, TLB inputs set to a multi-hit to show they are ignored
        acc("R1 p4", 32'hE123_4567, 0, 1, 1, 0, 2'd2, 0, M1K, 0, 0, 0);
        acc("R1 p4 top", 32'hFFFF_FFFC, 1, 1, 1, 1, 2'd0, 0, M1K, 0, 0, 0);
        acc("R1 p1", 32'h8C00_1234, 0, 1, 1, 0, 2'd0, 0, M1K, 0, 0, 0);
        acc("R1 p2 edge", 32'hBFFF_FFFF, 1, 1, 1, 0, 2'd0, 0, M1K, 0, 0, 0);
        // R3 privileged C0 region goes to translation; off here
        acc("R3 p3 off", 32'hC000_0000, 0, 1, 0, 0, 2'd0, 0, M1K, 0, 0, 0);
        acc("R3 low off", 32'h7ABC_DEF0, 1, 0, 0, 0, 2'd0, 0, M1K, 0, 0, 0);
        acc("R4 p3 miss", 32'hC000_0400, 0, 1, 1, 0, 2'd0, 0, M1K, 0, 0, 0);
        // R2 user windows
        acc("R2 sq ok", 32'hE000_0010, 1, 0, 1, 0, 2'd0, 0, M1K, 0, 0, 0);
        acc("R2 sq edge", 32'hE3FF_FFFF, 0, 0, 1, 0, 2'd0, 0, M1K, 0, 0, 0);
        acc("R2 sq out", 32'hE400_0000, 0, 0, 1, 0, 2'd0, 0, M1K, 0, 0, 0);
        acc("R2 sq dis", 32'hE000_0010, 1, 0, 1, 1, 2'd0, 0, M1K, 0, 0, 0);
        acc("R9 R2 user p1 wr", 32'h8000_0000, 1, 0, 1, 0, 2'd0, 0, M1K, 0, 0, 0);
        // R4 misses and multi-hits
        acc("R4 miss rd", 32'h0040_1000, 0, 0, 1, 0, 2'd0, 0, M1K, 1, 1, 1);
        acc("R4 miss wr", 32'h0040_2000, 1, 1, 1, 0, 2'd0, 0, M1K, 1, 1, 1);
        acc("R9 R4 multi over prot", 32'h0040_3000, 1, 0, 1, 0, 2'd3, 0, M1K, 0, 0, 0);
        acc("R4 multi2 rd", 32'h0040_4000, 0, 1, 1, 0, 2'd2, 0, M1K, 1, 1, 1);
        // R5 read protection
        acc("R5 user rd", 32'h0012_3456, 0, 0, 1, 0, 2'd1, 32'h0ABC_0000, M4K, 0, 1, 1);
        acc("R5 priv rd ok", 32'h0012_3456, 0, 1, 1, 0, 2'd1, 32'h0ABC_0000, M4K, 0, 0, 0);
        // R6 write protection
        acc("R6 priv nowr", 32'h0100_0800, 1, 1, 1, 0, 2'd1, 32'h0200_0000, M1K, 1, 0, 1);
        acc("R6 user nouser", 32'h0100_0800, 1, 0, 1, 0, 2'd1, 32'h0200_0000, M1K, 0, 1, 1);
        acc("R9 R6 prot over dirty", 32'h0100_0C00, 1, 0, 1, 0, 2'd1, 32'h0200_0000, M1K, 1, 0, 0);
        acc("R6 priv wr nouser ok", 32'h0100_0C04, 1, 1, 1, 0, 2'd1, 32'h0200_0000, M1K, 0, 1, 1);
        // R7 dirty
        acc("R7 user clean", 32'h0300_0004, 1, 0, 1, 0, 2'd1, 32'h0500_0000, M1M, 1, 1, 0);
        acc("R7 rd clean ok", 32'h0300_0004, 0, 0, 1, 0, 2'd1, 32'h0500_0000, M1M, 1, 0, 0);
        // R8 address formation
        acc("R8 1M", 32'h0345_6789, 1, 0, 1, 0, 2'd1, 32'h1FFF_FFFF, M1M, 1, 1, 1);
        acc("R8 1K", 32'h0000_07FF, 0, 1, 1, 0, 2'd1, 32'h0C00_0400, M1K, 0, 0, 0);
        // R10 strobe low and address error keep the stored fault address
        acc("R10 no strobe", 32'h0777_0000, 0, 0, 1, 0, 2'd0, 0, M1K, 0, 0, 0, 0);
        acc("R10 addr err", 32'hA000_0000, 0, 0, 1, 0, 2'd0, 0, M1K, 0, 0, 0, 1);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [31:0] msk;
            a = $urandom;
            case ($urandom_range(0, 3))
                0: a[31:26] = 6'b111000;
                1: a[31] = 1'b0;
                default: ;
            endcase
            case ($urandom_range(0, 3))
                0: msk = M1K;
                1: msk = M4K;
                2: msk = 32'hFFFF_0000;
                default: msk = M1M;
            endcase
            acc("rand", a, 1'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0),
                1'($urandom), 2'($urandom), $urandom & 32'h1FFF_FFFF, msk,
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule